// File: doc/BRIEF.md
# Pause-Frame Flow Controller

This block decides when a MAC's receive side should ask its link partner to stop sending, and when to let it resume. It compares the byte count of free receive packet memory against two programmable watermarks, expressed in kibibytes. When free space drops under the high mark it asks the transmit path for a pause frame carrying the maximum pause time (0xFFFF). Once that frame has gone out and free space climbs above the low mark, it asks for a pause frame with pause time zero, which releases the partner. Software can also force either kind of frame. Each forcing bit clears itself when the transmit path reports that the frame has gone out.

In half-duplex operation the block can instead jam incoming packets while the receive memory is past the high watermark. One mode jams every packet. The other jams only packets whose destination address matches the station. It also latches a received-pause event for software, shows the live received-pause state, and gates the transmitter while a received pause is running and flow control is enabled.

The pause request is a hold-until-done handshake. The block raises `pause_req_valid_o` with a stable `pause_req_time_o`. The transmit path holds it off for as long as it needs and answers with a one-cycle `pause_done_i`. Only one request is outstanding at a time, and a new one can start at the earliest one cycle after the done cycle. Building the frame, running the transmit engine and counting the received pause timer all happen outside this block.

Top module: `pause_flow_ctrl`

## Requirements
- R1: After reset the threshold register (address 0) reads 0x38 (high mark 3 in bits 7:4, low mark 8 in bits 3:0), the control register (address 1) reads 0x00, and neither a pause request nor a jam is raised.
- R2: A write to address 0 updates both watermarks. Read data appears on `reg_rdata_o` the cycle after `reg_rd_i`.
- R3: With control bit 5 (automatic pause) set, no max pause sent yet and no request outstanding, free bytes below high mark × 1024 raise a request with time 0xFFFF. With bit 5 clear, no automatic request is raised.
- R4: A high mark of 0 triggers the max-time request only when free bytes equal 0.
- R5: An automatic zero-time request is raised when free bytes exceed low mark × 1024, only after a 0xFFFF pause has completed. The zero-time request is not repeated once it has completed.
- R6: Control bit 7 forces a zero-time request and bit 6 forces a 0xFFFF request. Each clears itself on completion. Bit 7 wins over bit 6, and both win over automatic requests.
- R7: Once raised, the request stays valid with a stable time until the cycle `pause_done_i` is high, and it is low in the following cycle.
- R8: With `half_duplex_i` high and free bytes below high mark × 1024, `jam_req_o` pulses the cycle after `rx_pkt_start_i` if control bit 4 (jam any packet) is set, or if bit 3 (jam on address match) is set and `rx_da_match_i` is high. It never pulses in full duplex.
- R9: Control bit 2 latches on `rx_pause_seen_i` and clears when the control register is read. Bit 1 shows `rx_pause_active_i` live. Writes do not change bits 2 and 1.
- R10: `tx_halt_o` is high exactly when control bit 0 (flow-control enable) and `rx_pause_active_i` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_addr_i | input | 1 | 0 selects thresholds, 1 selects control/status |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (clears latched status on address 1) |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, valid the cycle after the read strobe |
| rx_free_bytes_i | input | FREE_W | Free bytes in receive memory |
| pause_req_valid_o | output | 1 | Pause frame request, held until done |
| pause_req_time_o | output | 16 | Requested pause time (0x0000 or 0xFFFF) |
| pause_done_i | input | 1 | Transmit path reports the pause frame sent |
| half_duplex_i | input | 1 | Link is half duplex |
| rx_pkt_start_i | input | 1 | Pulse: an incoming packet has begun |
| rx_da_match_i | input | 1 | Destination address of that packet matches the station |
| jam_req_o | output | 1 | One-cycle jam request |
| rx_pause_seen_i | input | 1 | Pulse: a pause frame was received |
| rx_pause_active_i | input | 1 | Received pause timer is running |
| tx_halt_o | output | 1 | Stop transmission |

## Verification
The bench builds the block with the default 14-bit free-space count. This reaches a high mark of 15 (15 360 bytes), so the last byte under the top watermark can be probed, and a high mark of 0 can be tried against an empty and a one-byte-free memory. The vector table resets the block before each case, so every watermark decision starts with no max pause sent. Directed tests then walk the arming sequence, the forced-bit priority, both jam modes and the read-to-clear status.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  localparam int REG_W    = 8;
  localparam int WM_W     = REG_W / 2;
  localparam int KB_SHIFT = 10;
  localparam int TIME_W   = 16;

  localparam int C_FZERO  = 7;
  localparam int C_FMAX   = 6;
  localparam int C_AUTO   = 5;
  localparam int C_BPANY  = 4;
  localparam int C_BPDA   = 3;
  localparam int C_LATCH  = 2;
  localparam int C_LIVE   = 1;
  localparam int C_FCEN   = 0;

  localparam logic [WM_W-1:0] HW_RESET = WM_W'(3);
  localparam logic [WM_W-1:0] LW_RESET = WM_W'(8);

  typedef enum logic [1:0] {
    K_FZERO = 2'd0,
    K_FMAX  = 2'd1,
    K_AMAX  = 2'd2,
    K_AZERO = 2'd3
  } req_kind_e;
endpackage

// File: rtl/pfc_regs.sv
module pfc_regs
  import pfc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_addr_i,
  input  logic             reg_wr_i,
  input  logic             reg_rd_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  input  logic             clr_fzero_i,
  input  logic             clr_fmax_i,
  input  logic             rx_pause_seen_i,
  input  logic             rx_pause_active_i,
  output logic [WM_W-1:0]  hw_o,
  output logic [WM_W-1:0]  lw_o,
  output logic             fzero_o,
  output logic             fmax_o,
  output logic             auto_o,
  output logic             bp_any_o,
  output logic             bp_da_o,
  output logic             fc_en_o
);
  logic wr_thr, wr_ctl, rd_ctl;
  logic latch_q;
  logic [REG_W-1:0] ctl_view;

  assign wr_thr = reg_wr_i && !reg_addr_i;
  assign wr_ctl = reg_wr_i &&  reg_addr_i;
  assign rd_ctl = reg_rd_i &&  reg_addr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hw_o <= HW_RESET;
      lw_o <= LW_RESET;
    end else if (wr_thr) begin
      hw_o <= reg_wdata_i[REG_W-1:WM_W];
      lw_o <= reg_wdata_i[WM_W-1:0];
    end
  end

  // software write wins over completion clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fzero_o  <= 1'b0;
      fmax_o   <= 1'b0;
      auto_o   <= 1'b0;
      bp_any_o <= 1'b0;
      bp_da_o  <= 1'b0;
      fc_en_o  <= 1'b0;
    end else if (wr_ctl) begin
      fzero_o  <= reg_wdata_i[C_FZERO];
      fmax_o   <= reg_wdata_i[C_FMAX];
      auto_o   <= reg_wdata_i[C_AUTO];
      bp_any_o <= reg_wdata_i[C_BPANY];
      bp_da_o  <= reg_wdata_i[C_BPDA];
      fc_en_o  <= reg_wdata_i[C_FCEN];
    end else begin
      if (clr_fzero_i) fzero_o <= 1'b0;
      if (clr_fmax_i)  fmax_o  <= 1'b0;
    end
  end

  // a new event in the read cycle stays latched
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              latch_q <= 1'b0;
    else if (rx_pause_seen_i) latch_q <= 1'b1;
    else if (rd_ctl)          latch_q <= 1'b0;
  end

  always_comb begin
    ctl_view          = '0;
    ctl_view[C_FZERO] = fzero_o;
    ctl_view[C_FMAX]  = fmax_o;
    ctl_view[C_AUTO]  = auto_o;
    ctl_view[C_BPANY] = bp_any_o;
    ctl_view[C_BPDA]  = bp_da_o;
    ctl_view[C_LATCH] = latch_q;
    ctl_view[C_LIVE]  = rx_pause_active_i;
    ctl_view[C_FCEN]  = fc_en_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       reg_rdata_o <= '0;
    else if (reg_rd_i) reg_rdata_o <= reg_addr_i ? ctl_view : {hw_o, lw_o};
  end

  a_r9_latch_on_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_pause_seen_i |=> latch_q);
  a_r9_clear_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ctl && !rx_pause_seen_i |=> !latch_q);
  a_r6_force_selfclear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_fzero_i && !wr_ctl |=> !fzero_o);
endmodule

// File: rtl/pfc_pause_arb.sv
module pfc_pause_arb
  import pfc_pkg::*;
#(
  parameter int FREE_W = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FREE_W-1:0] free_i,
  input  logic [WM_W-1:0]   hw_i,
  input  logic [WM_W-1:0]   lw_i,
  input  logic              auto_i,
  input  logic              fzero_i,
  input  logic              fmax_i,
  input  logic              done_i,
  output logic              valid_o,
  output logic [TIME_W-1:0] time_o,
  output logic              clr_fzero_o,
  output logic              clr_fmax_o,
  output logic              over_hw_o
);
  localparam int WM_BYTES_W = WM_W + KB_SHIFT;
  localparam int CMP_W = (FREE_W > WM_BYTES_W) ? FREE_W : WM_BYTES_W;

  logic [CMP_W-1:0] free_c, hw_bytes, lw_bytes;
  logic under_low, above_low;
  logic busy_q, hw_sent_q;
  req_kind_e kind_q, kind_d;
  logic start;
  logic finish;

  assign free_c   = CMP_W'(free_i);
  assign hw_bytes = CMP_W'({hw_i, {KB_SHIFT{1'b0}}});
  assign lw_bytes = CMP_W'({lw_i, {KB_SHIFT{1'b0}}});

  // high mark of zero: only an empty memory counts as short
  assign under_low = (hw_i == '0) ? (free_c == '0) : (free_c < hw_bytes);
  assign above_low = free_c > lw_bytes;
  assign over_hw_o = under_low;

  always_comb begin
    start  = 1'b1;
    kind_d = K_FZERO;
    if (fzero_i)                               kind_d = K_FZERO;
    else if (fmax_i)                           kind_d = K_FMAX;
    else if (auto_i && !hw_sent_q && under_low) kind_d = K_AMAX;
    else if (auto_i && hw_sent_q && above_low)  kind_d = K_AZERO;
    else                                        start = 1'b0;
  end

  assign finish = busy_q && done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      kind_q <= K_FZERO;
    end else if (finish) begin
      busy_q <= 1'b0;
    end else if (!busy_q && start) begin
      busy_q <= 1'b1;
      kind_q <= kind_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hw_sent_q <= 1'b0;
    else if (finish) hw_sent_q <= (kind_q == K_FMAX) || (kind_q == K_AMAX);
  end

  assign valid_o     = busy_q;
  assign time_o      = ((kind_q == K_FMAX) || (kind_q == K_AMAX)) ? {TIME_W{1'b1}} : '0;
  assign clr_fzero_o = finish && (kind_q == K_FZERO);
  assign clr_fmax_o  = finish && (kind_q == K_FMAX);

  a_r7_hold_until_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !done_i |=> valid_o && $stable(time_o));
  a_r7_drop_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && done_i |=> !valid_o);
  a_r5_zero_needs_arming: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && kind_q == K_AZERO |-> hw_sent_q);
  a_r3_auto_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) && kind_q == K_AMAX |-> $past(auto_i));
endmodule

// File: rtl/pfc_backpressure.sv
module pfc_backpressure (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic half_duplex_i,
  input  logic over_hw_i,
  input  logic bp_any_i,
  input  logic bp_da_i,
  input  logic pkt_start_i,
  input  logic da_match_i,
  output logic jam_o
);
  logic want;

  assign want = half_duplex_i && over_hw_i && pkt_start_i &&
                (bp_any_i || (bp_da_i && da_match_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) jam_o <= 1'b0;
    else         jam_o <= want;
  end

  a_r8_half_duplex_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jam_o |-> $past(half_duplex_i) && $past(pkt_start_i));
  a_r8_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pkt_start_i |=> !jam_o);
endmodule

// File: rtl/pause_flow_ctrl.sv
module pause_flow_ctrl
  import pfc_pkg::*;
#(
  parameter int FREE_W = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_addr_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  input  logic [FREE_W-1:0] rx_free_bytes_i,
  output logic              pause_req_valid_o,
  output logic [15:0]       pause_req_time_o,
  input  logic              pause_done_i,
  input  logic              half_duplex_i,
  input  logic              rx_pkt_start_i,
  input  logic              rx_da_match_i,
  output logic              jam_req_o,
  input  logic              rx_pause_seen_i,
  input  logic              rx_pause_active_i,
  output logic              tx_halt_o
);
  logic [WM_W-1:0] hw, lw;
  logic fzero, fmax, auto_en, bp_any, bp_da, fc_en;
  logic clr_fzero, clr_fmax, over_hw;

  pfc_regs u_regs (
    .clk_i, .rst_ni, .reg_addr_i, .reg_wr_i, .reg_rd_i, .reg_wdata_i, .reg_rdata_o,
    .clr_fzero_i(clr_fzero), .clr_fmax_i(clr_fmax),
    .rx_pause_seen_i, .rx_pause_active_i,
    .hw_o(hw), .lw_o(lw), .fzero_o(fzero), .fmax_o(fmax), .auto_o(auto_en),
    .bp_any_o(bp_any), .bp_da_o(bp_da), .fc_en_o(fc_en)
  );

  pfc_pause_arb #(.FREE_W(FREE_W)) u_arb (
    .clk_i, .rst_ni, .free_i(rx_free_bytes_i), .hw_i(hw), .lw_i(lw),
    .auto_i(auto_en), .fzero_i(fzero), .fmax_i(fmax), .done_i(pause_done_i),
    .valid_o(pause_req_valid_o), .time_o(pause_req_time_o),
    .clr_fzero_o(clr_fzero), .clr_fmax_o(clr_fmax), .over_hw_o(over_hw)
  );

  pfc_backpressure u_bp (
    .clk_i, .rst_ni, .half_duplex_i, .over_hw_i(over_hw),
    .bp_any_i(bp_any), .bp_da_i(bp_da), .pkt_start_i(rx_pkt_start_i),
    .da_match_i(rx_da_match_i), .jam_o(jam_req_o)
  );

  assign tx_halt_o = fc_en && rx_pause_active_i;

  a_r10_halt_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_halt_o |-> rx_pause_active_i);
endmodule

// File: tb/pause_flow_ctrl_tb.sv
module pause_flow_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int FREE_W = 14;

  logic clk = 1'b0, rst_n = 1'b0;
  logic addr = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic [FREE_W-1:0] free = '0;
  logic pvalid; logic [15:0] ptime;
  logic pdone = 1'b0, hdx = 1'b0, pkt = 1'b0, dam = 1'b0, jam;
  logic pseen = 1'b0, pact = 1'b0, halt;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pause_flow_ctrl #(.FREE_W(FREE_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .rx_free_bytes_i(free),
    .pause_req_valid_o(pvalid), .pause_req_time_o(ptime), .pause_done_i(pdone),
    .half_duplex_i(hdx), .rx_pkt_start_i(pkt), .rx_da_match_i(dam), .jam_req_o(jam),
    .rx_pause_seen_i(pseen), .rx_pause_active_i(pact), .tx_halt_o(halt)
  );

  // hw, lw, auto, free, expect valid, expect time
  typedef struct packed {
    logic [3:0] hw; logic [3:0] lw; logic au; logic [13:0] fr; logic ev; logic [15:0] et;
  } vec_t;
  localparam int NV = 8;
  localparam vec_t VT [NV] = '{
    '{4'd3,  4'd8, 1'b1, 14'd3071,  1'b1, 16'hFFFF},
    '{4'd3,  4'd8, 1'b1, 14'd3072,  1'b0, 16'h0000},
    '{4'd3,  4'd8, 1'b0, 14'd100,   1'b0, 16'h0000},
    '{4'd0,  4'd8, 1'b1, 14'd0,     1'b1, 16'hFFFF},
    '{4'd0,  4'd8, 1'b1, 14'd1,     1'b0, 16'h0000},
    '{4'd15, 4'd8, 1'b1, 14'd15359, 1'b1, 16'hFFFF},
    '{4'd3,  4'd8, 1'b1, 14'd9000,  1'b0, 16'h0000},
    '{4'd3,  4'd2, 1'b1, 14'd2500,  1'b1, 16'hFFFF}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic wr_reg(input logic a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic finish_pause();
    @(negedge clk); pdone = 1'b1;
    @(negedge clk); pdone = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] r;
    do_reset();
    // R1 reset state
    rd_reg(1'b0, r); chk("R1 threshold reset", r, 8'h38);
    rd_reg(1'b1, r); chk("R1 control reset", r, 8'h00);
    chk("R1 no request", pvalid, 0); chk("R1 no jam", jam, 0);

    // R2 threshold readback
    wr_reg(1'b0, 8'h5A); rd_reg(1'b0, r); chk("R2 threshold write", r, 8'h5A);

    // R3/R4 table of watermark decisions, each from reset
    for (int i = 0; i < NV; i++) begin
      free = '1;
      do_reset();
      wr_reg(1'b0, {VT[i].hw, VT[i].lw});
      free = VT[i].fr;
      wr_reg(1'b1, {2'b00, VT[i].au, 5'b0});
      settle();
      chk((VT[i].hw == 0) ? "R4 zero high mark" : "R3 auto max", pvalid, VT[i].ev);
      if (VT[i].ev) chk("R3 max time", ptime, VT[i].et);
    end

    // R5 arming sequence
    free = '1; do_reset();
    wr_reg(1'b1, 8'h20);
    free = 14'd9000; settle();
    chk("R5 no zero before max", pvalid, 0);
    free = 14'd2000; settle();
    chk("R5 max raised", pvalid, 1); chk("R5 max time", ptime, 16'hFFFF);
    repeat (3) @(negedge clk);
    chk("R7 held while waiting", pvalid, 1); chk("R7 time stable", ptime, 16'hFFFF);
    finish_pause();
    chk("R7 drops after done", pvalid, 0);
    settle(); chk("R5 no repeat max", pvalid, 0);
    free = 14'd8192; settle(); chk("R5 at low mark no zero", pvalid, 0);
    free = 14'd9000; settle();
    chk("R5 zero raised", pvalid, 1); chk("R5 zero time", ptime, 16'h0000);
    finish_pause(); settle(); chk("R5 zero not repeated", pvalid, 0);

    // R6 forced priority and self-clear
    free = '1; do_reset();
    wr_reg(1'b1, 8'hC0); settle();
    chk("R6 zero forced first", ptime, 16'h0000); chk("R6 valid", pvalid, 1);
    finish_pause();
    rd_reg(1'b1, r); chk("R6 bit7 self-cleared", r, 8'h40);
    settle(); chk("R6 max forced", ptime, 16'hFFFF);
    finish_pause();
    rd_reg(1'b1, r); chk("R6 bit6 self-cleared", r, 8'h00);
    free = 14'd100; wr_reg(1'b1, 8'hA0); settle();
    chk("R6 force beats auto", ptime, 16'h0000);
    finish_pause(); settle();
    chk("R6 auto after force", ptime, 16'hFFFF); chk("R6 auto valid", pvalid, 1);
    finish_pause();

    // R8 back-pressure
    free = 14'd1000; do_reset();
    wr_reg(1'b1, 8'h10); hdx = 1'b1;
    @(negedge clk); pkt = 1'b1; @(negedge clk); pkt = 1'b0;
    chk("R8 jam any", jam, 1);
    @(negedge clk); chk("R8 jam one cycle", jam, 0);
    hdx = 1'b0;
    @(negedge clk); pkt = 1'b1; @(negedge clk); pkt = 1'b0;
    chk("R8 no jam full duplex", jam, 0);
    hdx = 1'b1; wr_reg(1'b1, 8'h08);
    @(negedge clk); pkt = 1'b1; dam = 1'b0; @(negedge clk); pkt = 1'b0;
    chk("R8 da mode no match", jam, 0);
    @(negedge clk); pkt = 1'b1; dam = 1'b1; @(negedge clk); pkt = 1'b0; dam = 1'b0;
    chk("R8 da mode match", jam, 1);
    free = 14'd5000;
    @(negedge clk); pkt = 1'b1; dam = 1'b1; @(negedge clk); pkt = 1'b0; dam = 1'b0;
    chk("R8 no jam with space", jam, 0);
    hdx = 1'b0;

    // R9 status
    do_reset();
    @(negedge clk); pseen = 1'b1; @(negedge clk); pseen = 1'b0;
    rd_reg(1'b1, r); chk("R9 latched", r, 8'h04);
    rd_reg(1'b1, r); chk("R9 read cleared", r, 8'h00);
    pact = 1'b1; rd_reg(1'b1, r); chk("R9 live bit", r, 8'h02);
    wr_reg(1'b1, 8'h04); rd_reg(1'b1, r); chk("R9 write ignored", r, 8'h02);

    // R10 halt
    chk("R10 no halt disabled", halt, 0);
    wr_reg(1'b1, 8'h01); @(negedge clk); chk("R10 halt", halt, 1);
    pact = 1'b0; @(negedge clk); chk("R10 halt released", halt, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule